// File: doc/BRIEF.md
# Hybrid stochastic/binary second-order IIR section

This block is one second-order recursive filter section. The five coefficient multiplications are done on unipolar stochastic bit streams, with a separate sign bit. Every addition and every filter state stays in signed two's-complement binary. An operation starts with a one-cycle `start` pulse. The block then turns each operand magnitude (the current sample, two past inputs and two past outputs) into a stream by comparing it with an externally supplied random value. It does the same for each coefficient magnitude, using a second random value. The two streams are ANDed bit by bit. For each product the block counts the 1s over Nsto = 2^n − 1 stream cycles.

In one extra binary cycle the five counts are scaled, signed and summed. The sum is clipped to the sample range and the delay line is advanced. `done` then pulses with the new output. The output has the same format as the input, so sections chain directly into longer cascades. The random source lies outside the block. It steps its generator on every cycle in which `strm_en` is high. If it restarts its sequence on each `start`, every operation uses the same fixed random sequence.

Coefficients are sign-magnitude numbers. A magnitude m stands for the fraction m / 2^(DATA_W−1). The feedback coefficients are supplied already negated, so all five terms are added.

Top module: `stoch_biquad`

## Requirements
- R1: While reset is held and just after it is released, `y_out` is 0 and `done`, `busy` and `strm_en` are 0. All four delay states read as zero.
- R2: A `start` seen at a rising edge while idle raises `busy` in the following cycle. `done` is high for exactly one cycle, Nsto + 1 cycles after the accepting edge. In that same cycle `y_out` carries the new result and `busy` is low.
- R3: Each product count equals the number of stream cycles in which both comparisons hold, as unsigned compares: operand magnitude > `rnd_data`, and coefficient magnitude > `rnd_coef`.
- R4: A product term is negative exactly when the operand is negative XOR the coefficient sign bit is 1.
- R5: Each count is shifted left by (DATA_W − 1 − n) and signed. The five terms are then summed in binary.
- R6: A sum above 2^(DATA_W−1) − 1 gives that value, and a sum below −2^(DATA_W−1) gives that value. Neither wraps.
- R7: Term k uses the coefficient field `coef_mag[10k+9:10k]` with sign `coef_neg[k]`. Term k = 0..4 multiplies x[n], x[n−1], x[n−2], y[n−1] and y[n−2] in that order. The delay line shifts only at the end of an operation, and y[n−1] takes the clipped output.
- R8: `len_log2` = n is sampled when `start` is accepted, and Nsto = 2^n − 1. A value of 0 acts as 1, and a value above DATA_W − 1 acts as DATA_W − 1.
- R9: A `start` pulse during an operation is ignored. `x_in` and `len_log2` at that time change neither the result nor the timing.
- R10: The operand −2^(DATA_W−1) is given magnitude 2^(DATA_W−1) − 1, so it gives the same term as −(2^(DATA_W−1) − 1).
- R11: `strm_en` is high in exactly Nsto consecutive cycles, starting in the cycle after the accepting edge. The random inputs are used at the rising edge that ends each of these cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one stream bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when idle |
| x_in | input | DATA_W | Signed input sample, captured on an accepted start |
| len_log2 | input | NW | Stream length exponent n, Nsto = 2^n − 1 |
| coef_neg | input | 5 | Coefficient sign bits, bit k for term k |
| coef_mag | input | 5*(DATA_W−1) | Coefficient magnitudes, field k for term k |
| rnd_data | input | DATA_W−1 | Random value compared with operand magnitudes |
| rnd_coef | input | DATA_W−1 | Random value compared with coefficient magnitudes |
| busy | output | 1 | An operation is in progress |
| strm_en | output | 1 | Stream cycle; the random source steps on it |
| y_out | output | DATA_W | Signed, clipped output of the last operation |
| done | output | 1 | One-cycle pulse when `y_out` is new |

## Verification
If a product counter misses a clear, or keeps counting one cycle too long, the error shows only as a wrong `y_out` at the next `done`. It does not appear earlier. A corrupted delay state is worse: it feeds back into y[n−1] and stays in every later output, so the bench follows a model across whole sequences of operations and does not check single samples in isolation. A length decode or stream-window fault moves `done` away from cycle Nsto + 1, and the bench sees that within the same operation.

// File: rtl/stoch_biquad_pkg.sv
package stoch_biquad_pkg;

  localparam int unsigned NUM_TERMS = 5;

  localparam int unsigned TERM_X0 = 0;
  localparam int unsigned TERM_X1 = 1;
  localparam int unsigned TERM_X2 = 2;
  localparam int unsigned TERM_Y1 = 3;
  localparam int unsigned TERM_Y2 = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STREAM = 2'd1,
    PH_BIN    = 2'd2
  } op_phase_e;

endpackage

// File: rtl/stoch_biquad_ctrl.sv
module stoch_biquad_ctrl
  import stoch_biquad_pkg::*;
#(
  parameter int unsigned RW = 10,
  parameter int unsigned NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] len_log2,
  output logic          accept,
  output logic          strm_en,
  output logic          bin_en,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] n_eff
);

  localparam logic [NW-1:0] N_MAX = NW'(RW);

  // limit the requested exponent to 1..RW
  function automatic logic [NW-1:0] clamp_len(input logic [NW-1:0] l);
    if (l == '0) return NW'(1);
    if (l > N_MAX) return N_MAX;
    return l;
  endfunction

  // stream length 2^n - 1
  function automatic logic [RW-1:0] len_to_nsto(input logic [NW-1:0] n);
    logic [RW:0] p;
    p = (RW+1)'(1) << n;
    p = p - (RW+1)'(1);
    return p[RW-1:0];
  endfunction

  op_phase_e     st_q;
  logic [NW-1:0] n_q;
  logic [RW-1:0] phase_q;
  logic [RW-1:0] nsto;
  logic          last_slot;

  assign nsto      = len_to_nsto(n_q);
  assign n_eff     = n_q;
  assign accept    = start && (st_q == PH_IDLE);
  assign strm_en   = (st_q == PH_STREAM);
  assign bin_en    = (st_q == PH_BIN);
  assign busy      = (st_q != PH_IDLE);
  assign last_slot = strm_en && (phase_q == nsto - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      n_q     <= NW'(1);
      phase_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= (st_q == PH_BIN);
      unique case (st_q)
        PH_IDLE: begin
          if (start) begin
            n_q     <= clamp_len(len_log2);
            phase_q <= '0;
            st_q    <= PH_STREAM;
          end
        end
        PH_STREAM: begin
          if (last_slot) st_q <= PH_BIN;
          else           phase_q <= phase_q + RW'(1);
        end
        PH_BIN:  st_q <= PH_IDLE;
        default: st_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stoch_biquad_term.sv
module stoch_biquad_term #(
  parameter int unsigned RW    = 10,
  parameter int unsigned NW    = 4,
  parameter int unsigned SUM_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic [RW:0]             operand,
  input  logic                    coef_neg,
  input  logic [RW-1:0]           coef_mag,
  input  logic [RW-1:0]           rnd_data,
  input  logic [RW-1:0]           rnd_coef,
  input  logic [NW-1:0]           n_eff,
  output logic signed [SUM_W-1:0] term
);

  // absolute value, most negative code folded onto the largest magnitude
  function automatic logic [RW-1:0] mag_sat(input logic [RW:0] v);
    logic [RW:0] a;
    a = v[RW] ? (~v + (RW+1)'(1)) : v;
    return a[RW] ? '1 : a[RW-1:0];
  endfunction

  // count of ones back to a signed binary term in sample units
  function automatic logic signed [SUM_W-1:0] to_binary(input logic [RW-1:0] cnt,
                                                         input logic neg,
                                                         input logic [NW-1:0] n);
    logic [SUM_W-1:0] m;
    logic [NW-1:0]    sh;
    sh = NW'(RW) - n;
    m  = SUM_W'(cnt) << sh;
    return neg ? -$signed(m) : $signed(m);
  endfunction

  logic [RW-1:0] op_mag;
  logic          data_bit;
  logic          coef_bit;
  logic          prod_bit;
  logic          prod_neg;
  logic [RW-1:0] ones_q;

  assign op_mag   = mag_sat(operand);
  assign data_bit = op_mag > rnd_data;
  assign coef_bit = coef_mag > rnd_coef;
  assign prod_bit = data_bit & coef_bit;
  assign prod_neg = operand[RW] ^ coef_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ones_q <= '0;
    else if (clr)              ones_q <= '0;
    else if (en && prod_bit)   ones_q <= ones_q + RW'(1);
  end

  assign term = to_binary(ones_q, prod_neg, n_eff);

endmodule

// File: rtl/stoch_biquad.sv
module stoch_biquad
  import stoch_biquad_pkg::*;
#(
  parameter  int unsigned DATA_W = 11,
  localparam int unsigned RW     = DATA_W - 1,
  localparam int unsigned NW     = $clog2(RW + 1),
  localparam int unsigned SUM_W  = DATA_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic [NW-1:0]            len_log2,
  input  logic [NUM_TERMS-1:0]     coef_neg,
  input  logic [NUM_TERMS*RW-1:0]  coef_mag,
  input  logic [RW-1:0]            rnd_data,
  input  logic [RW-1:0]            rnd_coef,
  output logic                     busy,
  output logic                     strm_en,
  output logic signed [DATA_W-1:0] y_out,
  output logic                     done
);

  localparam int                       Y_HI_I = (1 << (DATA_W - 1)) - 1;
  localparam logic signed [DATA_W-1:0] Y_HI   = DATA_W'(Y_HI_I);
  localparam logic signed [DATA_W-1:0] Y_LO   = ~Y_HI;
  localparam logic signed [SUM_W-1:0]  S_HI   = SUM_W'(Y_HI_I);
  localparam logic signed [SUM_W-1:0]  S_LO   = ~S_HI;

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [SUM_W-1:0] s);
    if (s > S_HI) return Y_HI;
    if (s < S_LO) return Y_LO;
    return $signed(s[DATA_W-1:0]);
  endfunction

  logic                     accept;
  logic                     bin_en;
  logic [NW-1:0]            n_eff;
  logic signed [DATA_W-1:0] x0_q, x1_q, x2_q, y1_q, y2_q, y_q;
  logic [DATA_W-1:0]        operand [NUM_TERMS];
  logic signed [SUM_W-1:0]  term    [NUM_TERMS];
  logic signed [SUM_W-1:0]  sum_raw;
  logic signed [DATA_W-1:0] y_next;

  stoch_biquad_ctrl #(.RW(RW), .NW(NW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len_log2 (len_log2),
    .accept   (accept),
    .strm_en  (strm_en),
    .bin_en   (bin_en),
    .busy     (busy),
    .done     (done),
    .n_eff    (n_eff)
  );

  assign operand[TERM_X0] = x0_q;
  assign operand[TERM_X1] = x1_q;
  assign operand[TERM_X2] = x2_q;
  assign operand[TERM_Y1] = y1_q;
  assign operand[TERM_Y2] = y2_q;

  for (genvar k = 0; k < NUM_TERMS; k++) begin : g_term
    stoch_biquad_term #(.RW(RW), .NW(NW), .SUM_W(SUM_W)) u_term (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .en       (strm_en),
      .operand  (operand[k]),
      .coef_neg (coef_neg[k]),
      .coef_mag (coef_mag[k*RW +: RW]),
      .rnd_data (rnd_data),
      .rnd_coef (rnd_coef),
      .n_eff    (n_eff),
      .term     (term[k])
    );
  end

  always_comb begin
    sum_raw = '0;
    for (int k = 0; k < NUM_TERMS; k++) sum_raw = sum_raw + term[k];
  end

  assign y_next = clip(sum_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q <= '0;
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
      y_q  <= '0;
    end else begin
      if (accept) x0_q <= x_in;
      if (bin_en) begin
        y_q  <= y_next;
        x1_q <= x0_q;
        x2_q <= x1_q;
        y1_q <= y_next;
        y2_q <= y1_q;
      end
    end
  end

  assign y_out = y_q;

endmodule

// File: rtl/stoch_biquad_chk.sv
module stoch_biquad_chk #(
  parameter int unsigned DATA_W = 11,
  parameter int unsigned NW     = 4,
  parameter int unsigned SUM_W  = 14
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [NW-1:0]            len_log2,
  input logic                     busy,
  input logic                     strm_en,
  input logic                     bin_en,
  input logic                     done,
  input logic signed [DATA_W-1:0] y_out,
  input logic signed [SUM_W-1:0]  sum_raw
);

  localparam int unsigned              RW     = DATA_W - 1;
  localparam int                       Y_HI_I = (1 << (DATA_W - 1)) - 1;
  localparam logic signed [DATA_W-1:0] Y_HI   = DATA_W'(Y_HI_I);
  localparam logic signed [DATA_W-1:0] Y_LO   = ~Y_HI;
  localparam logic signed [SUM_W-1:0]  S_HI   = SUM_W'(Y_HI_I);
  localparam logic signed [SUM_W-1:0]  S_LO   = ~S_HI;

  function automatic logic [RW:0] want_len(input logic [NW-1:0] l);
    int n;
    n = int'(l);
    if (n < 1) n = 1;
    if (n > int'(RW)) n = int'(RW);
    return (RW+1)'((1 << n) - 1);
  endfunction

  logic [RW:0] exp_len;
  logic [RW:0] strm_cnt;
  logic [RW:0] op_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_len  <= '0;
      strm_cnt <= '0;
      op_cnt   <= '0;
    end else if (start && !busy) begin
      exp_len  <= want_len(len_log2);
      strm_cnt <= '0;
      op_cnt   <= '0;
    end else begin
      if (strm_en) strm_cnt <= strm_cnt + (RW+1)'(1);
      if (busy)    op_cnt   <= op_cnt + (RW+1)'(1);
    end
  end

  a_r2_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_op_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (op_cnt == exp_len + (RW+1)'(1)));

  a_r11_strm_window: assert property (@(posedge clk) disable iff (!rst_n)
    strm_en |-> (strm_cnt < exp_len));

  a_r11_strm_total: assert property (@(posedge clk) disable iff (!rst_n)
    bin_en |-> (strm_cnt == exp_len));

  a_r6_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_en && (sum_raw > S_HI)) |=> (y_out == Y_HI));

  a_r6_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_en && (sum_raw < S_LO)) |=> (y_out == Y_LO));

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_out) |-> done);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start && strm_en) |=> (strm_en || bin_en));

endmodule

bind stoch_biquad stoch_biquad_chk #(.DATA_W(DATA_W), .NW(NW), .SUM_W(SUM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .len_log2 (len_log2),
  .busy     (busy),
  .strm_en  (strm_en),
  .bin_en   (bin_en),
  .done     (done),
  .y_out    (y_out),
  .sum_raw  (sum_raw)
);

// File: tb/stoch_biquad_bench.sv
module stoch_biquad_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int DW = 11;
  localparam int RW = 10;
  localparam int NW = 4;
  localparam int NT = 5;

  logic                 clk      = 1'b0;
  logic                 rst_n    = 1'b0;
  logic                 start    = 1'b0;
  logic signed [DW-1:0] x_in     = '0;
  logic [NW-1:0]        len_log2 = '0;
  logic [NT-1:0]        coef_neg = '0;
  logic [NT*RW-1:0]     coef_mag = '0;
  logic [RW-1:0]        rnd_data = '0;
  logic [RW-1:0]        rnd_coef = '0;
  logic                 busy;
  logic                 strm_en;
  logic signed [DW-1:0] y_out;
  logic                 done;

  int checks = 0;
  int errors = 0;
  int m_x1, m_x2, m_y1, m_y2;
  int seq_d [1024];
  int seq_c [1024];
  int last_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  stoch_biquad u_stoch_biquad (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .x_in     (x_in),
    .len_log2 (len_log2),
    .coef_neg (coef_neg),
    .coef_mag (coef_mag),
    .rnd_data (rnd_data),
    .rnd_coef (rnd_coef),
    .busy     (busy),
    .strm_en  (strm_en),
    .y_out    (y_out),
    .done     (done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    if (l < 1) return 1;
    if (l > RW) return RW;
    return l;
  endfunction

  function automatic int mag_of(input int v);
    if (v < 0) return (-v > 1023) ? 1023 : -v;
    return v;
  endfunction

  function automatic int lfsr_step(input int s, input int n);
    int mask, fb, v;
    case (n)
      2: mask = 'h3;   3: mask = 'h6;   4: mask = 'hC;   5: mask = 'h14;
      6: mask = 'h30;  7: mask = 'h60;  8: mask = 'hB8;  9: mask = 'h110;
      10: mask = 'h240;
      default: mask = 'h1;
    endcase
    v = s & mask;
    fb = 0;
    for (int b = 0; b < 10; b++) fb = fb ^ ((v >> b) & 1);
    return ((s << 1) | fb) & ((1 << n) - 1);
  endfunction

  function automatic int bit_rev(input int s, input int n);
    int r = 0;
    for (int b = 0; b < n; b++) if ((s >> b) & 1) r = r | (1 << (n - 1 - b));
    return r;
  endfunction

  function automatic int coef_val(input int cset, input int k);
    if (cset == -1) return 1023;
    if (cset == -2 || cset == -3) return (k == 0) ? 1023 : 0;
    return (cset * 173 + k * 389 + 57) % 1024;
  endfunction

  function automatic bit coef_sgn(input int cset, input int k);
    if (cset == -1 || cset == -2) return 1'b0;
    if (cset == -3) return (k == 0);
    return ((cset + k) % 3) == 0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(y_out == 0 && !done && !busy && !strm_en, "R1", "state in reset", int'(y_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(y_out == 0 && !done && !busy && !strm_en, "R1", "state after reset", int'(y_out), 0);
    m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0;
  endtask

  // one full operation: model, drive, check timing and result
  task automatic run_op(input int x, input int len, input int cset, input string req, input bit poke);
    int n, ns, s, sum, cnt, tv, expy;
    int ops [NT];
    int cm [NT];
    bit cn [NT];
    bit tim_ok;
    n  = eff_len(len);
    ns = (1 << n) - 1;
    s  = 1;
    for (int t = 0; t < ns; t++) begin
      seq_d[t] = s << (RW - n);
      seq_c[t] = bit_rev(s, n) << (RW - n);
      s = lfsr_step(s, n);
    end
    ops[0] = x; ops[1] = m_x1; ops[2] = m_x2; ops[3] = m_y1; ops[4] = m_y2;
    sum = 0;
    for (int k = 0; k < NT; k++) begin
      cm[k] = coef_val(cset, k);
      cn[k] = coef_sgn(cset, k);
      cnt = 0;
      for (int t = 0; t < ns; t++)
        if (mag_of(ops[k]) > seq_d[t] && cm[k] > seq_c[t]) cnt++;
      tv = cnt << (RW - n);
      if ((ops[k] < 0) ^ cn[k]) tv = -tv;
      sum += tv;
    end
    expy = (sum > 1023) ? 1023 : ((sum < -1024) ? -1024 : sum);

    for (int k = 0; k < NT; k++) begin
      coef_mag[k*RW +: RW] = RW'(cm[k]);
      coef_neg[k]          = cn[k];
    end
    x_in     = DW'(x);
    len_log2 = NW'(len);
    start    = 1'b1;
    tim_ok   = 1'b1;
    for (int t = 0; t < ns; t++) begin
      @(negedge clk);
      rnd_data = RW'(seq_d[t]);
      rnd_coef = RW'(seq_c[t]);
      if (!strm_en || !busy || done) tim_ok = 1'b0;
      if (poke && t == 0) begin
        start    = 1'b1;
        x_in     = ~x_in;
        len_log2 = 4'd15;
      end else begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    start = 1'b0;
    check(tim_ok, "R11", "stream window", int'(tim_ok), 1);
    check(busy && !strm_en && !done, "R2", "binary cycle flags", int'(done), 0);
    @(negedge clk);
    check(done && !busy, "R2", "done after Nsto+1 cycles", int'(done), 1);
    check(int'(y_out) == expy, req, "output sample", int'(y_out), expy);
    last_y = int'(y_out);
    m_x2 = m_x1; m_x1 = x; m_y2 = m_y1; m_y1 = expy;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int yref;
    do_reset();

    // R3/R7 sweep of the input range at a short stream, state carried along
    for (int x = -1024; x <= 1023; x += 41) run_op(x, 3, 7, "R3/R7", 1'b0);

    // R5 every stream length with varied coefficients; R9 start pokes while busy
    for (int l = 1; l <= RW; l++)
      for (int i = 0; i < 6; i++) begin
        int xv;
        xv = (i == 0) ? -1024 : ((i == 1) ? 1023 : ((l * 97 + i * 311) % 2048) - 1024);
        run_op(xv, l, l * 6 + i, (i == 3) ? "R9" : "R5", i == 3);
      end

    // R8 out-of-range exponents
    run_op(200, 0, 3, "R8", 1'b0);
    run_op(-300, 15, 4, "R8", 1'b0);

    // R4 positive sample with a negative coefficient
    do_reset();
    run_op(500, 4, -3, "R4", 1'b0);
    check(last_y < 0, "R4", "sign of product", last_y, -448);
    check(last_y == -448, "R4", "product value", last_y, -448);

    // R6 positive and negative clipping
    do_reset();
    for (int i = 0; i < 3; i++) run_op(1023, 10, -1, "R6", 1'b0);
    check(last_y == 1023, "R6", "clip high", last_y, 1023);
    do_reset();
    for (int i = 0; i < 3; i++) run_op(-1024, 10, -1, "R6", 1'b0);
    check(last_y == -1024, "R6", "clip low", last_y, -1024);

    // R10 most negative code matches its neighbour
    do_reset();
    run_op(-1023, 10, -2, "R10", 1'b0);
    yref = last_y;
    run_op(-1024, 10, -2, "R10", 1'b0);
    check(last_y == yref, "R10", "most negative operand", last_y, yref);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule